// File: doc/BRIEF.md
# Second-Operand Shifter with Rotated-Immediate Generator

This block forms the second operand of an integer ALU together with the carry produced by the shifter. An immediate path widens an 8-bit constant to the datapath width and rotates it right by an even amount taken from a 4-bit field. A register path sends a register value through a barrel shifter. The shifter supports logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the carry flag. The shift amount is either a 5-bit constant or the low byte of a second register.

Every shift case produces an exact carry-out. This includes register amounts of zero, exactly the datapath width, and beyond it. The flag logic of the ALU can therefore take the carry without any correction.

One pipeline register sits between the inputs and the outputs. A result appears one cycle after its valid strobe. The output holds its value while no new input is presented.

Top module: `opnd2_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `operand` and `carry_out` read 0 until the first valid input is captured.
- R2: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, `operand` and `carry_out` keep their previous values, whatever the other inputs do.
- R3: With `use_imm`=1, `operand` is `imm_byte` zero-extended and rotated right by 2×`imm_rot`. `carry_out` equals `carry_in` when `imm_rot` is 0. Otherwise it equals bit 31 of the result.
- R4: The shift amount is `amt_field` when `amt_from_reg`=0 and `rs_value[7:0]` when it is 1; bits [31:8] of `rs_value` have no effect. For `shift_kind` codes 0 to 3, an amount of 0 passes `rm_value` and `carry_in` through unchanged.
- R5: `shift_kind`=0 (logical left) by n in 1..31 gives `rm_value<<n` with carry equal to bit 32-n. By 32 it gives 0 with carry equal to bit 0. Above 32 it gives 0 with carry 0.
- R6: `shift_kind`=1 (logical right) by n in 1..31 gives `rm_value>>n` with carry equal to bit n-1. By 32 it gives 0 with carry equal to bit 31. Above 32 it gives 0 with carry 0.
- R7: `shift_kind`=2 (arithmetic right) fills vacated bits with bit 31, with carry equal to bit n-1 for n in 1..31. For n of 32 or more, every bit and the carry equal bit 31.
- R8: `shift_kind`=3 (rotate right) rotates by n modulo 32 with carry equal to bit 31 of the result. This includes a nonzero multiple of 32, which leaves the value unchanged.
- R9: `shift_kind`=4 (rotate through carry) gives `{carry_in, rm_value[31:1]}` with carry equal to `rm_value[0]`, and it ignores the amount.
- R10: `shift_kind` codes 5, 6 and 7 pass `rm_value` and `carry_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input fields are valid this cycle |
| use_imm | input | 1 | 1 selects the immediate path, 0 the register path |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field (rotation is twice this value) |
| rm_value | input | 32 | Register value to shift |
| shift_kind | input | 3 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| amt_from_reg | input | 1 | 1 takes the amount from rs_value[7:0] |
| amt_field | input | 5 | Constant shift amount |
| rs_value | input | 32 | Register holding the shift amount |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | operand and carry_out are new this cycle |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The hardest cases to reach are the register amounts at and above the datapath width. Here the shift and carry rules break from the in-range pattern, and a nonzero multiple of 32 under rotate keeps the value yet changes the carry. The stimulus reaches these cases directly. It sets `amt_from_reg` and loads `rs_value` with bytes such as 32, 33, 64 and 255. It also fills the upper bits of `rs_value` with garbage so that any leak of those bits shows up. The expected values come from a bit-serial model that shifts one position at a time. The boundary results then follow from repeated single steps rather than from a copy of the case rules.

// File: rtl/opnd2_pkg.sv
// Shared types for the second-operand unit.
// Assumes: shift kinds fit in 3 bits; codes 5..7 are reserved and pass through.
package opnd2_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/opnd2_imm_rot.sv
// Rotated-immediate generator: widens a small constant and rotates it right
// by twice the rotate field. Carry is the old carry for a zero rotate,
// otherwise the top bit of the result.
// Assumes: 2*(2**ROT_W-1) < DATA_W and DATA_W is a power of two.
module opnd2_imm_rot #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] imm_value,
    output logic              imm_carry
);
    localparam int SHW = $clog2(DATA_W);

    logic [DATA_W-1:0]   widened;
    logic [SHW-1:0]      rot_amt;
    logic [2*DATA_W-1:0] doubled;

    // Widen, double the rotate field and rotate with a doubled word.
    always_comb begin
        widened   = DATA_W'(imm_byte);
        rot_amt   = SHW'({imm_rot, 1'b0});
        doubled   = {widened, widened} >> rot_amt;
        imm_value = doubled[DATA_W-1:0];
        imm_carry = (imm_rot == '0) ? carry_in : imm_value[DATA_W-1];
    end

endmodule

// File: rtl/opnd2_barrel.sv
// Barrel shifter with exact carry-out for every amount, including amounts
// equal to or beyond the word width.
// Assumes: DATA_W is a power of two and fits in an AMT_W-bit amount.
module opnd2_barrel
    import opnd2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] value,
    input  logic [2:0]        kind,
    input  logic [AMT_W-1:0]  amount,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    localparam int SHW = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

    logic [SHW-1:0]      lo;
    logic [SHW-1:0]      up_idx;
    logic [SHW-1:0]      dn_idx;
    logic                zero_amt;
    logic                in_range;
    logic                at_full;
    logic [DATA_W-1:0]   shl_v;
    logic [DATA_W-1:0]   shr_v;
    logic [DATA_W-1:0]   sar_v;
    logic [2*DATA_W-1:0] rot_d;
    logic                msb;

    // Decode the amount into range flags and bit indices for the carry.
    always_comb begin
        lo       = amount[SHW-1:0];
        up_idx   = SHW'(0) - lo;
        dn_idx   = lo - SHW'(1);
        zero_amt = (amount == '0);
        in_range = (amount < FULL);
        at_full  = (amount == FULL);
        msb      = value[DATA_W-1];
    end

    // Form the raw shifted and rotated words.
    always_comb begin
        shl_v = value << lo;
        shr_v = value >> lo;
        sar_v = DATA_W'($signed(value) >>> lo);
        rot_d = {value, value} >> lo;
    end

    // Select the result and carry for the requested kind and amount class.
    always_comb begin
        result    = value;
        carry_out = carry_in;
        case (kind)
            SK_LSL: begin
                if (zero_amt) begin
                    result    = value;
                    carry_out = carry_in;
                end else if (in_range) begin
                    result    = shl_v;
                    carry_out = value[up_idx];
                end else begin
                    result    = '0;
                    carry_out = at_full ? value[0] : 1'b0;
                end
            end
            SK_LSR: begin
                if (zero_amt) begin
                    result    = value;
                    carry_out = carry_in;
                end else if (in_range) begin
                    result    = shr_v;
                    carry_out = value[dn_idx];
                end else begin
                    result    = '0;
                    carry_out = at_full ? msb : 1'b0;
                end
            end
            SK_ASR: begin
                if (zero_amt) begin
                    result    = value;
                    carry_out = carry_in;
                end else if (in_range) begin
                    result    = sar_v;
                    carry_out = value[dn_idx];
                end else begin
                    result    = {DATA_W{msb}};
                    carry_out = msb;
                end
            end
            SK_ROR: begin
                if (zero_amt) begin
                    result    = value;
                    carry_out = carry_in;
                end else begin
                    result    = rot_d[DATA_W-1:0];
                    carry_out = rot_d[DATA_W-1];
                end
            end
            SK_RRX: begin
                result    = {carry_in, value[DATA_W-1:1]};
                carry_out = value[0];
            end
            default: begin
                result    = value;
                carry_out = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/opnd2_unit.sv
// Second-operand unit: picks the rotated immediate or the barrel-shifted
// register, then registers operand and carry for one cycle of latency.
// Assumes: synchronous active-low reset; outputs hold when in_valid is low.
module opnd2_unit #(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4,
    parameter int AMT_IMM_W = 5,
    parameter int AMT_REG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 use_imm,
    input  logic [IMM_W-1:0]     imm_byte,
    input  logic [ROT_W-1:0]     imm_rot,
    input  logic [DATA_W-1:0]    rm_value,
    input  logic [2:0]           shift_kind,
    input  logic                 amt_from_reg,
    input  logic [AMT_IMM_W-1:0] amt_field,
    input  logic [DATA_W-1:0]    rs_value,
    input  logic                 carry_in,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    operand,
    output logic                 carry_out
);
    logic [AMT_REG_W-1:0] shift_amt;
    logic [DATA_W-1:0]    imm_value;
    logic                 imm_carry;
    logic [DATA_W-1:0]    sh_value;
    logic                 sh_carry;
    logic [DATA_W-1:0]    next_operand;
    logic                 next_carry;

    // Choose the constant amount or the low byte of the amount register.
    always_comb begin
        shift_amt = amt_from_reg ? rs_value[AMT_REG_W-1:0]
                                 : AMT_REG_W'(amt_field);
    end

    opnd2_imm_rot #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) imm_i (
        .imm_byte  (imm_byte),
        .imm_rot   (imm_rot),
        .carry_in  (carry_in),
        .imm_value (imm_value),
        .imm_carry (imm_carry)
    );

    opnd2_barrel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_REG_W)
    ) shift_i (
        .value     (rm_value),
        .kind      (shift_kind),
        .amount    (shift_amt),
        .carry_in  (carry_in),
        .result    (sh_value),
        .carry_out (sh_carry)
    );

    // Pick the path that feeds the output register.
    always_comb begin
        next_operand = use_imm ? imm_value : sh_value;
        next_carry   = use_imm ? imm_carry : sh_carry;
    end

    // Capture a new result on a valid input, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            operand   <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                operand   <= next_operand;
                carry_out <= next_carry;
            end
        end
    end

endmodule

// File: rtl/opnd2_unit_chk.sv
// Property checker for the second-operand unit, bound to every instance.
// Assumes the default 32-bit datapath for the boundary properties.
module opnd2_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        use_imm,
    input logic [7:0]  imm_byte,
    input logic [3:0]  imm_rot,
    input logic [31:0] rm_value,
    input logic [2:0]  shift_kind,
    input logic        amt_from_reg,
    input logic [31:0] rs_value,
    input logic        carry_in,
    input logic        out_valid,
    input logic [31:0] operand,
    input logic        carry_out
);
    logic reg_path;
    assign reg_path = in_valid && !use_imm && amt_from_reg;

    // R2: valid output exactly one cycle after a valid input.
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no valid input means outputs hold.
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(operand) && $stable(carry_out)));

    // R3: zero rotate gives the bare byte and the old carry.
    assert_imm_zero_rot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_imm && imm_rot == 4'd0) |=>
        (operand == {24'd0, $past(imm_byte)} && carry_out == $past(carry_in)));

    // R5: left shift beyond the width clears both value and carry.
    assert_lsl_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_path && shift_kind == 3'd0 && rs_value[7:0] > 8'd32) |=>
        (operand == 32'd0 && !carry_out));

    // R7: arithmetic right by 32 or more spreads the sign into all bits.
    assert_asr_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_path && shift_kind == 3'd2 && rs_value[7:0] >= 8'd32) |=>
        (operand == {32{$past(rm_value[31])}} && carry_out == $past(rm_value[31])));

    // R9: rotate through carry takes the old carry into the top bit.
    assert_rrx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_imm && shift_kind == 3'd4) |=>
        (operand[31] == $past(carry_in) && carry_out == $past(rm_value[0])));

endmodule

bind opnd2_unit opnd2_unit_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .use_imm      (use_imm),
    .imm_byte     (imm_byte),
    .imm_rot      (imm_rot),
    .rm_value     (rm_value),
    .shift_kind   (shift_kind),
    .amt_from_reg (amt_from_reg),
    .rs_value     (rs_value),
    .carry_in     (carry_in),
    .out_valid    (out_valid),
    .operand      (operand),
    .carry_out    (carry_out)
);

// File: tb/opnd2_unit_tb_top.sv
// Scoreboard bench: the driver queues expected results from a bit-serial
// model, and the monitor compares them as results appear.
module opnd2_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        use_imm = 1'b0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic [31:0] rm_value = '0;
    logic [2:0]  shift_kind = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  amt_field = '0;
    logic [31:0] rs_value = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] operand;
    logic        carry_out;

    typedef struct {
        logic [31:0] op;
        logic        c;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    opnd2_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .use_imm      (use_imm),
        .imm_byte     (imm_byte),
        .imm_rot      (imm_rot),
        .rm_value     (rm_value),
        .shift_kind   (shift_kind),
        .amt_from_reg (amt_from_reg),
        .amt_field    (amt_field),
        .rs_value     (rs_value),
        .carry_in     (carry_in),
        .out_valid    (out_valid),
        .operand      (operand),
        .carry_out    (carry_out)
    );

    // Bit-serial reference: one position per step, carry = last bit out.
    task automatic model_reg(input logic [31:0] v, input logic [2:0] k,
                             input int n, input logic cin,
                             output logic [31:0] r, output logic c);
        r = v;
        c = cin;
        if (k == 3'd4) begin
            c = v[0];
            r = {cin, v[31:1]};
        end else if (k <= 3'd3) begin
            for (int i = 0; i < n; i++) begin
                case (k)
                    3'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
                    3'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
                    3'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
                    default: begin c = r[0]; r = {r[0], r[31:1]}; end
                endcase
            end
        end
    endtask

    task automatic check(input string req, input logic [31:0] act_op,
                         input logic act_c, input logic [31:0] exp_op,
                         input logic exp_c);
        checks++;
        if (act_op !== exp_op || act_c !== exp_c) begin
            errors++;
            $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                     req, act_op, act_c, exp_op, exp_c);
        end
    endtask

    task automatic drive_imm(input logic [7:0] b, input logic [3:0] rot,
                             input logic cin, input string req);
        exp_t e;
        logic [31:0] r;
        logic c;
        @(negedge clk);
        in_valid = 1'b1; use_imm = 1'b1; imm_byte = b; imm_rot = rot;
        carry_in = cin;
        rm_value = 32'hDEAD_BEEF; shift_kind = 3'd0; amt_from_reg = 1'b0;
        amt_field = 5'd3;
        r = {24'd0, b};
        c = cin;
        for (int i = 0; i < 2 * int'(rot); i++) begin
            c = r[0];
            r = {r[0], r[31:1]};
        end
        e.op = r; e.c = c; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic drive_reg(input logic [2:0] k, input logic from_reg,
                             input logic [4:0] a5, input logic [31:0] rs,
                             input logic [31:0] v, input logic cin,
                             input string req);
        exp_t e;
        logic [31:0] r;
        logic c;
        int n;
        @(negedge clk);
        in_valid = 1'b1; use_imm = 1'b0; imm_byte = 8'h5A; imm_rot = 4'd7;
        shift_kind = k; amt_from_reg = from_reg; amt_field = a5;
        rs_value = rs; rm_value = v; carry_in = cin;
        n = from_reg ? int'(rs[7:0]) : int'(a5);
        model_reg(v, k, n, cin, r, c);
        e.op = r; e.c = c; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2: unexpected out_valid, operand=%h expected no result",
                         operand);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, operand, carry_out, e.op, e.c);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_op;
        logic        held_c;
        logic [31:0] lcg;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 during reset", operand, carry_out, 32'd0, 1'b0);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid=%b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", operand, carry_out, 32'd0, 1'b0);

        // R3: immediate path
        drive_imm(8'hA5, 4'd0, 1'b1, "R3 rot0 carry kept");
        drive_imm(8'hA5, 4'd0, 1'b0, "R3 rot0 carry clear kept");
        drive_imm(8'hFF, 4'd4, 1'b0, "R3 rot8");
        drive_imm(8'h01, 4'd1, 1'b1, "R3 rot2 carry from bit31");
        drive_imm(8'h81, 4'd15, 1'b0, "R3 rot30");

        // R4: amount source and zero amount
        drive_reg(3'd0, 1'b0, 5'd0, 32'h0, 32'h8000_0001, 1'b1, "R4 zero const lsl");
        drive_reg(3'd1, 1'b1, 5'd9, 32'hFFFF_FF00, 32'h1234_5678, 1'b0, "R4 zero reg lsr upper ignored");
        drive_reg(3'd2, 1'b1, 5'd0, 32'hABCD_EF04, 32'h8000_00F0, 1'b1, "R4 reg amount low byte");
        drive_reg(3'd3, 1'b1, 5'd4, 32'h0000_0100, 32'hCAFE_F00D, 1'b1, "R4 ror zero reg");

        // R5: logical left
        drive_reg(3'd0, 1'b0, 5'd4, 32'h0, 32'hF000_000F, 1'b0, "R5 lsl 4");
        drive_reg(3'd0, 1'b0, 5'd31, 32'h0, 32'h0000_0003, 1'b0, "R5 lsl 31");
        drive_reg(3'd0, 1'b1, 5'd0, 32'hABCD_EF20, 32'h0000_0001, 1'b0, "R5 lsl 32");
        drive_reg(3'd0, 1'b1, 5'd0, 32'h0000_0021, 32'hFFFF_FFFF, 1'b1, "R5 lsl 33");
        drive_reg(3'd0, 1'b1, 5'd0, 32'h0000_00FF, 32'hFFFF_FFFF, 1'b1, "R5 lsl 255");

        // R6: logical right
        drive_reg(3'd1, 1'b0, 5'd1, 32'h0, 32'h8000_0001, 1'b0, "R6 lsr 1");
        drive_reg(3'd1, 1'b0, 5'd31, 32'h0, 32'hC000_0000, 1'b0, "R6 lsr 31");
        drive_reg(3'd1, 1'b1, 5'd0, 32'h0000_0020, 32'h8000_0000, 1'b0, "R6 lsr 32");
        drive_reg(3'd1, 1'b1, 5'd0, 32'h5500_0028, 32'hFFFF_FFFF, 1'b1, "R6 lsr 40");

        // R7: arithmetic right
        drive_reg(3'd2, 1'b0, 5'd4, 32'h0, 32'h8000_0018, 1'b0, "R7 asr 4 negative");
        drive_reg(3'd2, 1'b0, 5'd4, 32'h0, 32'h7000_0017, 1'b0, "R7 asr 4 positive");
        drive_reg(3'd2, 1'b1, 5'd0, 32'h0000_0020, 32'h8000_0000, 1'b0, "R7 asr 32 negative");
        drive_reg(3'd2, 1'b1, 5'd0, 32'h0000_00C8, 32'h7FFF_FFFF, 1'b1, "R7 asr 200 positive");

        // R8: rotate right
        drive_reg(3'd3, 1'b0, 5'd8, 32'h0, 32'h1234_5680, 1'b0, "R8 ror 8");
        drive_reg(3'd3, 1'b1, 5'd0, 32'h0000_0040, 32'h8000_0001, 1'b0, "R8 ror 64");
        drive_reg(3'd3, 1'b1, 5'd0, 32'h0000_0020, 32'h7FFF_FFFF, 1'b1, "R8 ror 32");
        drive_reg(3'd3, 1'b1, 5'd0, 32'h0000_0021, 32'h0000_0003, 1'b0, "R8 ror 33");

        // R9: rotate through carry
        drive_reg(3'd4, 1'b0, 5'd7, 32'h0, 32'h0000_0001, 1'b1, "R9 rrx carry in 1");
        drive_reg(3'd4, 1'b1, 5'd0, 32'h0000_0044, 32'hFFFF_FFFE, 1'b0, "R9 rrx carry in 0");

        // R10: reserved kinds
        drive_reg(3'd5, 1'b0, 5'd3, 32'h0, 32'h1357_9BDF, 1'b1, "R10 code 5");
        drive_reg(3'd6, 1'b1, 5'd0, 32'h0000_0010, 32'h2468_ACE0, 1'b0, "R10 code 6");
        drive_reg(3'd7, 1'b0, 5'd17, 32'h0, 32'hFEDC_BA98, 1'b1, "R10 code 7");

        // Sweep across kinds and amounts (R5 R6 R7 R8 R9)
        lcg = 32'h1ACE_B00C;
        for (int i = 0; i < 60; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            drive_reg(3'(i % 5), lcg[0], lcg[9:5],
                      {lcg[31:24], 16'h0, 8'(i * 7)}, lcg ^ 32'h9E37_79B9,
                      lcg[3], "R5-sweep R6 R7 R8 R9");
        end

        idle();
        repeat (3) @(negedge clk);

        // R2: inputs change with in_valid low, outputs must hold
        held_op = operand;
        held_c  = carry_out;
        rm_value = 32'h0BAD_0BAD; use_imm = 1'b1; imm_byte = 8'h77;
        carry_in = ~held_c;
        repeat (3) @(negedge clk);
        check("R2 hold while idle", operand, carry_out, held_op, held_c);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: out_valid=%b expected 0", out_valid);
        end
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d results missing expected 0", sb_q.size());
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule